// File: doc/BRIEF.md
# Alarm Match and Ringer Controller

This block sits beside a running 24-hour clock and sounds a buzzer when the clock's hour and minute reach a stored alarm time. Both times arrive as four BCD digits (hour tens, hour units, minute tens, minute units). Ringing begins only when all four digits agree while the alarm is armed. The buzzer is driven with an on/off beep rhythm and not a steady tone.

Ringing ends by itself after a fixed number of system-clock cycles (one minute at 50 MHz by default), or at once on a stop pulse. After either ending, the alarm stays quiet for the rest of the matching minute. It can ring again only once the clock has moved off the alarm time. One LED shows that the alarm is armed. A second LED copies the buzzer.

Top module: `alarm_ringer`

## Requirements
- R1: After reset the buzzer, the ringing LED and the armed LED are all 0.
- R2: A ring starts only when the clock hour tens, hour units, minute tens and minute units all equal the matching alarm digits while `arm` is 1. A mismatch in any single digit gives no ring. The buzzer goes high on the first clock edge at which the inputs match.
- R3: While `arm` is 0 the buzzer is 0, even when the time matches. A ring in progress stops one edge after `arm` falls.
- R4: `armed_led` copies `arm`, delayed by one clock edge.
- R5: While ringing, the buzzer is 1 for `HALF_BEEP` cycles and then 0 for `HALF_BEEP` cycles, and this repeats. The pattern starts in the on phase when the ring starts.
- R6: A ring lasts exactly `RING_CYCLES` cycles and then stops by itself.
- R7: A one-cycle `stop_pulse` ends a ring, and the buzzer is 0 from the next edge.
- R8: After a ring has ended, the alarm does not ring again while the time still matches. It can ring again once any digit has stopped matching and the times then match again.
- R9: `ring_led` equals `buzzer` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_hr_t | input | 2 | Clock hour tens, BCD 0-2 |
| now_hr_u | input | 4 | Clock hour units, BCD 0-9 |
| now_mn_t | input | 3 | Clock minute tens, BCD 0-5 |
| now_mn_u | input | 4 | Clock minute units, BCD 0-9 |
| set_hr_t | input | 2 | Alarm hour tens |
| set_hr_u | input | 4 | Alarm hour units |
| set_mn_t | input | 3 | Alarm minute tens |
| set_mn_u | input | 4 | Alarm minute units |
| arm | input | 1 | Alarm enable switch |
| stop_pulse | input | 1 | Debounced one-cycle manual stop |
| buzzer | output | 1 | Beep-patterned buzzer drive |
| armed_led | output | 1 | Armed indicator |
| ring_led | output | 1 | Ringing indicator, copy of buzzer |

## Verification
Every result appears after one register stage. Inputs applied before an edge show on `buzzer`, `ring_led` and `armed_led` just after that edge. The bench therefore drives on the falling edge and samples on the next falling edge. For the beep and timeout checks, the sample taken N falling edges after the start inputs were driven sees ring cycle N-1. The on/off phase of that sample is (N-1) mod 2*HALF_BEEP, and the last high-or-low cycle of ringing is RING_CYCLES. A short timeout and a short beep half-period keep these windows within a few dozen cycles.

// File: rtl/alarm_ringer.sv
module alarm_ringer #(
  parameter longint RING_CYCLES = 64'd3_000_000_000,
  parameter int     HALF_BEEP   = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] now_hr_t,
  input  logic [3:0] now_hr_u,
  input  logic [2:0] now_mn_t,
  input  logic [3:0] now_mn_u,
  input  logic [1:0] set_hr_t,
  input  logic [3:0] set_hr_u,
  input  logic [2:0] set_mn_t,
  input  logic [3:0] set_mn_u,
  input  logic       arm,
  input  logic       stop_pulse,
  output logic       buzzer,
  output logic       armed_led,
  output logic       ring_led
);

  localparam int RW = $clog2(RING_CYCLES + 1);
  localparam int BW = $clog2(2 * HALF_BEEP);
  localparam logic [RW-1:0] RING_LAST = RW'(RING_CYCLES - 1);
  localparam logic [BW-1:0] BEEP_LAST = BW'(2 * HALF_BEEP - 1);
  localparam logic [BW-1:0] BEEP_HALF = BW'(HALF_BEEP);

  logic          match, spent, ringing, start, armed_q;
  logic [RW-1:0] ring_cnt;
  logic [BW-1:0] beep_cnt;

  assign match = (now_hr_t == set_hr_t) && (now_hr_u == set_hr_u) &&
                 (now_mn_t == set_mn_t) && (now_mn_u == set_mn_u);
  assign start = arm && match && !spent && !ringing;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ringing <= 1'b0;
      spent   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= arm;
      spent   <= match && (spent || arm);
      if (!arm || stop_pulse)
        ringing <= 1'b0;
      else if (ringing && ring_cnt == RING_LAST)
        ringing <= 1'b0;
      else if (start)
        ringing <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ring_cnt <= '0;
      beep_cnt <= '0;
    end else if (!ringing) begin
      ring_cnt <= '0;
      beep_cnt <= '0;
    end else begin
      ring_cnt <= ring_cnt + 1'b1;
      beep_cnt <= (beep_cnt == BEEP_LAST) ? '0 : beep_cnt + 1'b1;
    end

  assign buzzer    = ringing && (beep_cnt < BEEP_HALF);
  assign ring_led  = buzzer;
  assign armed_led = armed_q;

  assert_disarm_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm) |-> !buzzer);
  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_pulse) |-> !ringing);
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ringing) |-> $past(arm && match && !spent));
  assert_led_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer |-> armed_led);
  assert_ring_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ringing |-> (ring_cnt < RW'(RING_CYCLES)));
  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ringing) |=> !ringing);

endmodule

// File: tb/sim_alarm_ringer.sv
module sim_alarm_ringer;
  localparam int RC = 40;
  localparam int HB = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] nht = 0, sht = 0;
  logic [3:0] nhu = 0, shu = 0, nmu = 0, smu = 0;
  logic [2:0] nmt = 0, smt = 0;
  logic arm = 0, stp = 0;
  logic buzzer, armed_led, ring_led;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  alarm_ringer #(.RING_CYCLES(RC), .HALF_BEEP(HB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .now_hr_t(nht), .now_hr_u(nhu), .now_mn_t(nmt), .now_mn_u(nmu),
    .set_hr_t(sht), .set_hr_u(shu), .set_mn_t(smt), .set_mn_u(smu),
    .arm(arm), .stop_pulse(stp),
    .buzzer(buzzer), .armed_led(armed_led), .ring_led(ring_led));

  // {now 13b, set 13b, arm, expected buzzer}
  localparam logic [27:0] VEC [8] = '{
    {13'h0A25, 13'h0A25, 1'b1, 1'b1},
    {13'h0A25, 13'h1A25, 1'b1, 1'b0},
    {13'h0A25, 13'h0B25, 1'b1, 1'b0},
    {13'h0A25, 13'h0A35, 1'b1, 1'b0},
    {13'h0A25, 13'h0A24, 1'b1, 1'b0},
    {13'h0A25, 13'h0A25, 1'b0, 1'b0},
    {13'h1359, 13'h1359, 1'b1, 1'b1},
    {13'h0000, 13'h0000, 1'b1, 1'b1}};

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_now(input logic [12:0] v);
    {nht, nhu, nmt, nmu} = v;
  endtask

  task automatic quiet();
    stp = 1; set_now(13'h1FFF); cyc(1); stp = 0; cyc(1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk(buzzer, 0, "R1 buzzer");
    chk(armed_led, 0, "R1 armed");
    chk(ring_led, 0, "R1 ringled");
    rst_n = 1;
    set_now(13'h1FFF);
    cyc(1);

    // R2 digit-match table
    for (int k = 0; k < 8; k++) begin
      quiet();
      arm = VEC[k][1];
      {sht, shu, smt, smu} = VEC[k][14:2];
      set_now(VEC[k][27:15]);
      cyc(1);
      chk(buzzer, VEC[k][0], $sformatf("R2 vector %0d", k));
      chk(ring_led, buzzer, "R9 led copy");
    end

    // R4 armed LED delay
    quiet(); arm = 0; cyc(1);
    chk(armed_led, 0, "R4 off");
    arm = 1;
    chk(armed_led, 0, "R4 before edge");
    cyc(1);
    chk(armed_led, 1, "R4 on");

    // R5 beep pattern and R6 timeout
    {sht, shu, smt, smu} = 13'h0A25;
    set_now(13'h0A25);
    for (int n = 1; n <= RC + 20; n++) begin
      cyc(1);
      if (n <= RC)
        chk(buzzer, ((n - 1) % (2 * HB)) < HB, $sformatf("R5 beep n=%0d", n));
      else
        chk(buzzer, 0, "R6 timed out");
      chk(ring_led, buzzer, "R9 led copy");
    end

    // R8 rearm after minute moves on
    set_now(13'h0A26); cyc(2);
    set_now(13'h0A25); cyc(1);
    chk(buzzer, 1, "R8 rearm");

    // R7 manual stop, R8 no restart in same minute
    cyc(2);
    stp = 1; cyc(1); stp = 0;
    chk(buzzer, 0, "R7 stopped");
    for (int n = 0; n < 30; n++) begin
      cyc(1);
      chk(buzzer, 0, "R8 held quiet");
    end

    // R3 disarm during ring
    set_now(13'h0A26); cyc(2);
    set_now(13'h0A25); cyc(1);
    chk(buzzer, 1, "R3 ringing before disarm");
    arm = 0; cyc(1);
    chk(buzzer, 0, "R3 disarm stops");
    chk(armed_led, 0, "R4 off after disarm");
    arm = 1; cyc(3);
    chk(buzzer, 0, "R8 rearm same minute quiet");

    // R1 reset mid-ring
    set_now(13'h0A26); cyc(2);
    set_now(13'h0A25); cyc(1);
    chk(buzzer, 1, "R2 ringing before reset");
    rst_n = 0; #1;
    chk(buzzer, 0, "R1 reset buzzer");
    chk(armed_led, 0, "R1 reset armed");
    cyc(1); rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule